// File: doc/BRIEF.md
# Doppler Zero-Velocity Masking Stage

This stage sits on the output of a Doppler FFT and removes energy near zero Doppler before later processing sees it. Each beat carries a packed complex sample, the Doppler bin it belongs to and a valid flag. When the bin lies within a host-chosen half-width of zero, the stage replaces the sample with zero. The half-width counts in both directions around bin zero and wraps to the top of a sub-frame of 2^SUB_BITS bins (16 by default). Valid and the bin index pass through unchanged.

The stage accepts one beat per clock and has no back-pressure. All outputs are delayed by the same fixed latency of LATENCY cycles (2 by default). The half-width is sampled together with each beat, so a new setting applies from the next beat accepted and leaves beats already in the pipeline unchanged. Setting the half-width to zero turns the mask off.

Top module: `dc_notch_mask`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0. Reset acts asynchronously and drops any beat in flight.
- R2: `out_valid` and `out_bin` equal `in_valid` and `in_bin` from exactly LATENCY clock edges earlier, with LATENCY = 2 by default. A cycle with `in_valid` low gives a cycle with `out_valid` low.
- R3: With `notch_half_width` = 0, every beat's `in_iq` appears unchanged on `out_iq`, whatever its bin.
- R4: With half-width W from 1 to 7, a beat is masked when its sub-frame position p satisfies p <= W or p >= 16-W. That is 2W+1 bins, and every other bin passes its data unchanged.
- R5: At W = 7, only sub-frame position 8 passes data, and all fifteen other positions are masked.
- R6: At W = 1, exactly positions 0, 1 and 15 are masked.
- R7: The sub-frame position is bits [3:0] of `in_bin`. The upper bin bits have no effect on masking.
- R8: A masked beat presents `out_iq` = 32'h0000_0000, and its `out_valid` and `out_bin` are the same as those of an unmasked beat.
- R9: The masking decision uses the `notch_half_width` value present in the cycle the beat is accepted. Changing it later does not alter that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| notch_half_width | input | 3 | Mask half-width W; 0 disables the mask |
| in_valid | input | 1 | Input beat valid |
| in_bin | input | 8 | Doppler bin index of the input beat |
| in_iq | input | 32 | Packed I/Q sample of the input beat |
| out_valid | output | 1 | Output beat valid |
| out_bin | output | 8 | Doppler bin index, delayed |
| out_iq | output | 32 | Sample, or zero when masked |

## Verification
The hardest case to reach from the ports is a half-width change while beats are still in the pipeline. The check is that each beat keeps the decision made when it was accepted. The stimulus changes W on consecutive beats that share a bin, going from the widest setting to off and back, so that wrongly sampling W at the output stage would flip the results. The boundary bins W, W+1, 15-W and 16-W are covered by sweeping all 16 positions at every W from 1 to 7. Some of these beats set the upper bin bits, and idle cycles are mixed in.

// File: rtl/dcn_pkg.sv
package dcn_pkg;
   // Default geometry of the masking stage.
   localparam int DCN_DATA_W   = 32;
   localparam int DCN_BIN_W    = 8;
   localparam int DCN_SUB_BITS = 4;
   localparam int DCN_WID_W    = 3;
   localparam int DCN_LATENCY  = 2;

   // Limit width: one bit wider than the sub-frame index so the span fits.
   function automatic int dcn_lim_w(input int sub_bits);
      return sub_bits + 1;
   endfunction
endpackage

// File: rtl/dcn_notch_limits.sv
module dcn_notch_limits
   import dcn_pkg::*;
#(
   parameter int WID_W    = DCN_WID_W,
   parameter int SUB_BITS = DCN_SUB_BITS,
   localparam int LIM_W   = dcn_lim_w(SUB_BITS)
) (
   input  logic [WID_W-1:0] half_width,
   output logic             enable,
   output logic [LIM_W-1:0] lim_lo,
   output logic [LIM_W-1:0] lim_hi
);
   localparam logic [LIM_W-1:0] SPAN = LIM_W'(2 ** SUB_BITS);

   always_comb begin
      enable = (half_width != '0);
      lim_lo = LIM_W'(half_width);
      lim_hi = SPAN - LIM_W'(half_width);
   end
endmodule

// File: rtl/dcn_bin_window.sv
module dcn_bin_window
   import dcn_pkg::*;
#(
   parameter int SUB_BITS = DCN_SUB_BITS,
   localparam int LIM_W   = dcn_lim_w(SUB_BITS)
) (
   input  logic [SUB_BITS-1:0] position,
   input  logic                enable,
   input  logic [LIM_W-1:0]    lim_lo,
   input  logic [LIM_W-1:0]    lim_hi,
   output logic                hit
);
   logic [LIM_W-1:0] pos_ext;

   always_comb begin
      pos_ext = LIM_W'(position);
      hit     = enable && ((pos_ext <= lim_lo) || (pos_ext >= lim_hi));
   end
endmodule

// File: rtl/dcn_delay_line.sv
module dcn_delay_line #(
   parameter int W         = 40,
   parameter int STAGES    = 2,
   parameter bit HOLD_IDLE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         d_valid,
   input  logic [W-1:0] d_data,
   output logic         q_valid,
   output logic [W-1:0] q_data
);
   logic [STAGES-1:0] vq;
   logic [W-1:0]      dq [STAGES];
   logic [STAGES-1:0] load;

   // With HOLD_IDLE the data registers only load behind a valid beat.
   generate
      if (HOLD_IDLE) begin : g_hold
         if (STAGES == 1) begin : g_one
            assign load = d_valid;
         end else begin : g_many
            assign load = {vq[STAGES-2:0], d_valid};
         end
      end else begin : g_free
         assign load = '1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) begin
            vq[i] <= 1'b0;
            dq[i] <= '0;
         end
      end else begin
         vq[0] <= d_valid;
         if (load[0]) dq[0] <= d_data;
         for (int i = 1; i < STAGES; i++) begin
            vq[i] <= vq[i-1];
            if (load[i]) dq[i] <= dq[i-1];
         end
      end
   end

   assign q_valid = vq[STAGES-1];
   assign q_data  = dq[STAGES-1];
endmodule

// File: rtl/dc_notch_mask.sv
module dc_notch_mask
   import dcn_pkg::*;
#(
   parameter int DATA_W    = DCN_DATA_W,
   parameter int BIN_W     = DCN_BIN_W,
   parameter int SUB_BITS  = DCN_SUB_BITS,
   parameter int WID_W     = DCN_WID_W,
   parameter int LATENCY   = DCN_LATENCY,
   parameter bit HOLD_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WID_W-1:0]  notch_half_width,
   input  logic              in_valid,
   input  logic [BIN_W-1:0]  in_bin,
   input  logic [DATA_W-1:0] in_iq,
   output logic              out_valid,
   output logic [BIN_W-1:0]  out_bin,
   output logic [DATA_W-1:0] out_iq
);
   localparam int LIM_W = dcn_lim_w(SUB_BITS);
   localparam int PKT_W = BIN_W + DATA_W;

   generate
      if (WID_W >= SUB_BITS) begin : g_bad_wid
         $error("half-width must stay below half the sub-frame");
      end
      if (BIN_W < SUB_BITS) begin : g_bad_bin
         $error("bin index narrower than sub-frame position");
      end
      if (LATENCY < 1) begin : g_bad_lat
         $error("latency must be at least one cycle");
      end
   endgenerate

   logic             win_en;
   logic [LIM_W-1:0] lim_lo;
   logic [LIM_W-1:0] lim_hi;
   logic             masked;
   logic [DATA_W-1:0] iq_sel;
   logic [PKT_W-1:0]  pkt_out;

   dcn_notch_limits #(
      .WID_W   (WID_W),
      .SUB_BITS(SUB_BITS)
   ) u_limits (
      .half_width(notch_half_width),
      .enable    (win_en),
      .lim_lo    (lim_lo),
      .lim_hi    (lim_hi)
   );

   dcn_bin_window #(
      .SUB_BITS(SUB_BITS)
   ) u_window (
      .position(in_bin[SUB_BITS-1:0]),
      .enable  (win_en),
      .lim_lo  (lim_lo),
      .lim_hi  (lim_hi),
      .hit     (masked)
   );

   assign iq_sel = masked ? '0 : in_iq;

   dcn_delay_line #(
      .W        (PKT_W),
      .STAGES   (LATENCY),
      .HOLD_IDLE(HOLD_IDLE)
   ) u_pipe (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_valid(in_valid),
      .d_data ({in_bin, iq_sel}),
      .q_valid(out_valid),
      .q_data (pkt_out)
   );

   assign out_bin = pkt_out[PKT_W-1:DATA_W];
   assign out_iq  = pkt_out[DATA_W-1:0];
endmodule

// File: rtl/dcn_checker.sv
module dcn_checker #(
   parameter int DATA_W   = 32,
   parameter int BIN_W    = 8,
   parameter int SUB_BITS = 4,
   parameter int WID_W    = 3,
   parameter int LATENCY  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [WID_W-1:0]  notch_half_width,
   input logic              in_valid,
   input logic [BIN_W-1:0]  in_bin,
   input logic [DATA_W-1:0] in_iq,
   input logic              out_valid,
   input logic [BIN_W-1:0]  out_bin,
   input logic [DATA_W-1:0] out_iq
);
   localparam int L = LATENCY - 1;
   localparam logic [WID_W-1:0] W_MAX = '1;
   localparam logic [SUB_BITS-1:0] MID = SUB_BITS'(2 ** (SUB_BITS - 1));
   localparam logic [SUB_BITS-1:0] TOP = '1;

   logic              hv [LATENCY];
   logic [BIN_W-1:0]  hb [LATENCY];
   logic [DATA_W-1:0] hd [LATENCY];
   logic [WID_W-1:0]  hw [LATENCY];
   int unsigned       fill;
   logic              primed;
   logic [SUB_BITS-1:0] hpos;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill <= 0;
         for (int i = 0; i < LATENCY; i++) begin
            hv[i] <= 1'b0; hb[i] <= '0; hd[i] <= '0; hw[i] <= '0;
         end
      end else begin
         if (fill < LATENCY) fill <= fill + 1;
         hv[0] <= in_valid; hb[0] <= in_bin; hd[0] <= in_iq; hw[0] <= notch_half_width;
         for (int i = 1; i < LATENCY; i++) begin
            hv[i] <= hv[i-1]; hb[i] <= hb[i-1]; hd[i] <= hd[i-1]; hw[i] <= hw[i-1];
         end
      end
   end

   assign primed = (fill >= LATENCY);
   assign hpos   = hb[L][SUB_BITS-1:0];

   always @(posedge clk) begin
      if (!rst_n) a_r1_reset_clears: assert (!out_valid);
   end

   a_r2_valid_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> (out_valid == hv[L]) && (!out_valid || out_bin == hb[L]));

   a_r3_disabled_passes: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && out_valid && hw[L] == '0) |-> out_iq == hd[L]);

   a_r5_center_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && out_valid && hw[L] == W_MAX && hpos == MID) |-> out_iq == hd[L]);

   a_r6_edges_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && out_valid && hw[L] == WID_W'(1) && (hpos == SUB_BITS'(1) || hpos == TOP))
      |-> out_iq == '0);

   a_r8_zero_or_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && out_valid) |-> (out_iq == '0 || out_iq == hd[L]));
endmodule

bind dc_notch_mask dcn_checker #(
   .DATA_W  (DATA_W),
   .BIN_W   (BIN_W),
   .SUB_BITS(SUB_BITS),
   .WID_W   (WID_W),
   .LATENCY (LATENCY)
) u_chk (.*);

// File: tb/dc_notch_mask_tb.sv
`timescale 1ns/1ps
module dc_notch_mask_tb;
   localparam int LAT = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  notch_half_width = '0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_bin = '0;
   logic [31:0] in_iq = '0;
   logic        out_valid;
   logic [7:0]  out_bin;
   logic [31:0] out_iq;

   int n_chk = 0;
   int n_fail = 0;

   logic        ev [LAT];
   logic [7:0]  eb [LAT];
   logic [31:0] ed [LAT];
   string       et [LAT];

   always #2.5 clk = ~clk;

   dc_notch_mask #(.LATENCY(LAT)) u_dut (
      .clk(clk), .rst_n(rst_n), .notch_half_width(notch_half_width),
      .in_valid(in_valid), .in_bin(in_bin), .in_iq(in_iq),
      .out_valid(out_valid), .out_bin(out_bin), .out_iq(out_iq)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Masked set built as a union of mirrored offsets around bin zero.
   function automatic bit in_notch(input int w, input logic [7:0] b);
      logic [15:0] m = '0;
      for (int k = 0; k <= w; k++) begin
         m[k] = 1'b1;
         m[(16 - k) % 16] = 1'b1;
      end
      return (w != 0) && m[b[3:0]];
   endfunction

   function automatic string tag_for(input int w);
      if (w == 0) return "R3";
      if (w == 7) return "R5";
      if (w == 1) return "R6";
      return "R4";
   endfunction

   task automatic clear_exp();
      for (int i = 0; i < LAT; i++) begin
         ev[i] = 1'b0; eb[i] = '0; ed[i] = '0; et[i] = "R2";
      end
   endtask

   // One clock: check the oldest expectation, then drive a new beat.
   task automatic step(input logic v, input int w, input logic [7:0] b,
                       input logic [31:0] d, input string tag);
      @(negedge clk);
      chk(out_valid === ev[LAT-1], "R2", "out_valid", 32'(out_valid), 32'(ev[LAT-1]));
      if (ev[LAT-1]) begin
         chk(out_bin === eb[LAT-1], "R2", "out_bin", 32'(out_bin), 32'(eb[LAT-1]));
         chk(out_iq === ed[LAT-1], et[LAT-1], "out_iq", out_iq, ed[LAT-1]);
      end
      for (int i = LAT - 1; i > 0; i--) begin
         ev[i] = ev[i-1]; eb[i] = eb[i-1]; ed[i] = ed[i-1]; et[i] = et[i-1];
      end
      ev[0] = v; eb[0] = b; ed[0] = in_notch(w, b) ? 32'h0 : d; et[0] = tag;
      in_valid = v; in_bin = b; in_iq = d; notch_half_width = 3'(w);
   endtask

   task automatic drain();
      for (int i = 0; i < LAT + 1; i++) step(1'b0, 0, 8'h00, 32'h0, "R2");
   endtask

   task automatic t_reset();
      in_valid = 1'b1; in_iq = 32'hDEAD_BEEF;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(out_valid === 1'b0, "R1", "out_valid in reset", 32'(out_valid), 32'h0);
      in_valid = 1'b0;
      rst_n = 1'b1;
      clear_exp();
      step(1'b0, 0, 8'h00, 32'h0, "R1");
      chk(out_valid === 1'b0, "R1", "out_valid after release", 32'(out_valid), 32'h0);
   endtask

   task automatic t_disabled();
      for (int b = 0; b < 16; b++)
         step(1'b1, 0, 8'(b), 32'hA5A5_0000 | 32'(b), "R3");
      drain();
   endtask

   task automatic t_sweep();
      for (int w = 1; w < 8; w++) begin
         for (int b = 0; b < 16; b++) begin
            step(1'b1, w, 8'(b), {8'(w), 8'(b), 16'h5A3C}, tag_for(w));
            if (b % 5 == 4) step(1'b0, w, 8'hFF, 32'h1234_5678, "R2");
         end
      end
      drain();
   endtask

   task automatic t_high_bits();
      step(1'b1, 2, 8'hF1, 32'h1111_1111, "R7");
      step(1'b1, 2, 8'h23, 32'h2222_2222, "R7");
      step(1'b1, 2, 8'h9E, 32'h3333_3333, "R7");
      step(1'b1, 2, 8'h4D, 32'h4444_4444, "R7");
      step(1'b1, 0, 8'hE0, 32'h5555_5555, "R7");
      drain();
   endtask

   task automatic t_zero_word();
      step(1'b1, 3, 8'h00, 32'hFFFF_FFFF, "R8");
      step(1'b1, 3, 8'h7D, 32'h8000_0001, "R8");
      step(1'b1, 3, 8'h04, 32'hFFFF_FFFF, "R8");
      drain();
   endtask

   task automatic t_switch();
      step(1'b1, 7, 8'h03, 32'hCAFE_0001, "R9");
      step(1'b1, 0, 8'h03, 32'hCAFE_0002, "R9");
      step(1'b1, 7, 8'h03, 32'hCAFE_0003, "R9");
      step(1'b1, 1, 8'h0F, 32'hCAFE_0004, "R9");
      step(1'b1, 0, 8'h0F, 32'hCAFE_0005, "R9");
      step(1'b1, 2, 8'h02, 32'hCAFE_0006, "R9");
      step(1'b1, 1, 8'h02, 32'hCAFE_0007, "R9");
      drain();
   endtask

   task automatic t_mid_reset();
      step(1'b1, 0, 8'h05, 32'h0BAD_F00D, "R1");
      step(1'b1, 0, 8'h06, 32'h0BAD_F00E, "R1");
      @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b0;
      #1;
      chk(out_valid === 1'b0, "R1", "out_valid on async reset", 32'(out_valid), 32'h0);
      clear_exp();
      @(negedge clk);
      rst_n = 1'b1;
      drain();
   endtask

   initial begin
      clear_exp();
      t_reset();
      t_disabled();
      t_sweep();
      t_high_bits();
      t_zero_word();
      t_switch();
      t_mid_reset();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #100000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule